// File: doc/BRIEF.md
# Zero-Crossing Soft Mute Controller

This block sits in a stereo sample path that runs at the input sample rate. It gates a left and a right signed sample stream with a single mute request. It does not cut the audio at an arbitrary instant. Each channel changes between passing its samples and driving zero only at a sample where that channel's waveform crosses zero. The change therefore adds no step to the signal, and neither muting nor unmuting produces an audible click.

A new sample pair arrives with a one-cycle strobe. The request is common to both channels, but each channel switches on its own crossing. A shared counter measures sample periods from the last change of the request. When a channel has found no crossing within `TIMEOUT` sample periods, the counter forces that channel to switch. A status flag reports when both channels are silent.

Top module: `zc_soft_mute`

## Requirements
- R1: While reset is asserted, both outputs read zero and `muted` reads 1. On the first clock after the internal reset releases, both channels take the state of `mute_req` directly: muted if it is 1, passing if it is 0.
- R2: On a strobe, a passing channel registers its input sample to its output. The new value appears after that clock edge.
- R3: On a strobe, a muted channel registers the value zero to its output.
- R4: A channel's sample is a zero crossing in either of two cases: the sample equals 0, or its sign bit (the MSB) differs from the sign bit of that channel's previous strobed sample. After reset, the previous sign counts as non-negative.
- R5: When a channel's state differs from `mute_req`, the channel changes at the first strobed sample that is a crossing. That sample is already output under the new state.
- R6: The two channels switch independently, each at its own crossing.
- R7: On the `TIMEOUT`-th strobe counted since `mute_req` last changed, every channel that still differs from the request adopts the request, whether or not that sample is a crossing.
- R8: Every change of `mute_req` restarts the strobe count. A strobe in the same cycle as the change counts as the first strobe.
- R9: If `mute_req` returns to a channel's current state before that channel has switched, the pending switch is dropped and the channel keeps its state.
- R10: `muted` is 1 exactly when both channels are muted. It rises only after a request of 1 and falls only after a request of 0.
- R11: Outside the first clock after reset, the outputs and `muted` change only at clock edges where the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| in_left | input | DATA_W | Left signed sample |
| in_right | input | DATA_W | Right signed sample |
| mute_req | input | 1 | 1 requests silence on both channels |
| out_left | output | DATA_W | Gated left sample |
| out_right | output | DATA_W | Gated right sample |
| muted | output | 1 | Both channels are muted |

## Verification
The bench builds the block with `DATA_W` = 12 and `TIMEOUT` = 8. With that small timeout, a forced switch happens after only eight samples. This makes both sides of the timeout reachable: the seventh strobe still passes audio and the eighth forces the switch. The bench can also let the count saturate, and can restart it part way through by toggling the request. With 12-bit samples, crossings can be driven from exact zero values and from sign changes, on each channel separately.

// File: rtl/zcm_pkg.sv
package zcm_pkg;
  localparam int unsigned NUM_CH = 2;

  function automatic logic is_crossing(input logic is_zero, input logic neg_now,
                                       input logic neg_prev);
    return is_zero | (neg_now ^ neg_prev);
  endfunction
endpackage

// File: rtl/zcm_rst_sync.sv
module zcm_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/zcm_timer.sv
module zcm_timer #(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic req,
  output logic force_o
);
  localparam int unsigned CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          req_q;
  logic          req_chg;
  logic [CW-1:0] cnt_q, cnt_d, cnt_eff;

  always_comb begin
    req_chg = req ^ req_q;
    cnt_eff = req_chg ? '0 : cnt_q;
    force_o = strobe && (cnt_eff == LAST);
    cnt_d   = cnt_eff;
    if (strobe && (cnt_eff != LAST)) cnt_d = cnt_eff + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/zcm_channel.sv
module zcm_channel #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init_done,
  input  logic                     strobe,
  input  logic                     target,
  input  logic                     force_i,
  input  logic signed [DATA_W-1:0] sample,
  output logic                     muted_o,
  output logic signed [DATA_W-1:0] out_o
);
  import zcm_pkg::*;

  logic                     muted_q, muted_d;
  logic                     neg_q, neg_d;
  logic signed [DATA_W-1:0] out_q, out_d;
  logic                     crossing;
  logic                     take;

  always_comb begin
    crossing = is_crossing(sample == '0, sample[DATA_W-1], neg_q);
    take     = (muted_q != target) && (crossing || force_i);
    muted_d  = muted_q;
    neg_d    = neg_q;
    out_d    = out_q;
    if (!init_done) begin
      muted_d = target;
    end else if (strobe) begin
      if (take) muted_d = target;
      out_d = muted_d ? '0 : sample;
      neg_d = sample[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      muted_q <= 1'b1;
      neg_q   <= 1'b0;
      out_q   <= '0;
    end else begin
      muted_q <= muted_d;
      neg_q   <= neg_d;
      out_q   <= out_d;
    end
  end

  assign muted_o = muted_q;
  assign out_o   = out_q;
endmodule

// File: rtl/zc_soft_mute.sv
module zc_soft_mute #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic                     mute_req,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     muted
);
  import zcm_pkg::*;

  logic                     rst_s;
  logic                     init_done;
  logic                     force_sw;
  logic signed [DATA_W-1:0] smp_arr [NUM_CH];
  logic signed [DATA_W-1:0] out_arr [NUM_CH];
  logic [NUM_CH-1:0]        mut_vec;

  zcm_rst_sync u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_s)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) init_done <= 1'b0;
    else        init_done <= 1'b1;
  end

  zcm_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_s),
    .strobe  (smp_valid & init_done),
    .req     (mute_req),
    .force_o (force_sw)
  );

  assign smp_arr[0] = in_left;
  assign smp_arr[1] = in_right;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    zcm_channel #(.DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_s),
      .init_done (init_done),
      .strobe    (smp_valid),
      .target    (mute_req),
      .force_i   (force_sw),
      .sample    (smp_arr[g]),
      .muted_o   (mut_vec[g]),
      .out_o     (out_arr[g])
    );
  end

  assign out_left  = out_arr[0];
  assign out_right = out_arr[1];
  assign muted     = &mut_vec;
endmodule

// File: rtl/zc_soft_mute_chk.sv
module zc_soft_mute_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TIMEOUT = 1024
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     init_done,
  input logic                     smp_valid,
  input logic                     mute_req,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right,
  input logic                     muted
);
  localparam int unsigned SW = $clog2(TIMEOUT + 1);
  localparam logic [SW-1:0] TOP = SW'(TIMEOUT);

  logic          req_q;
  logic [SW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      seen  <= '0;
    end else begin
      req_q <= mute_req;
      if (mute_req != req_q)         seen <= smp_valid ? SW'(1) : '0;
      else if (smp_valid && seen != TOP) seen <= seen + 1'b1;
    end
  end

  p_zero_when_muted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    muted |-> (out_left == '0 && out_right == '0));

  p_flag_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(muted) |-> $past(mute_req));

  p_flag_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(muted) |-> !$past(mute_req));

  p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(init_done) && !$past(smp_valid)) |->
      ($stable(out_left) && $stable(out_right) && $stable(muted)));

  p_timeout_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && seen == TOP && mute_req == req_q) |-> (muted == mute_req));
endmodule

bind zc_soft_mute zc_soft_mute_chk #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .init_done (init_done),
  .smp_valid (smp_valid),
  .mute_req  (mute_req),
  .out_left  (out_left),
  .out_right (out_right),
  .muted     (muted)
);

// File: tb/tb_zc_soft_mute.sv
module tb_zc_soft_mute;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int TO = 8;

  logic                 clk;
  logic                 rst_n;
  logic                 smp_valid;
  logic signed [DW-1:0] in_left, in_right;
  logic                 mute_req;
  logic signed [DW-1:0] out_left, out_right;
  logic                 muted;

  zc_soft_mute #(.DATA_W(DW), .TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .in_left(in_left),
    .in_right(in_right), .mute_req(mute_req), .out_left(out_left),
    .out_right(out_right), .muted(muted)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R1";
  bit    live    = 0;

  // behavioural reference state
  bit m_ml, m_mr, m_nl, m_nr, m_reqp;
  int m_cnt, m_ol, m_or;

  task automatic check_val(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_update();
    int  l, r, ce;
    bit  frc, zl, zr;
    l  = int'(in_left);
    r  = int'(in_right);
    ce = (mute_req != m_reqp) ? 0 : m_cnt;
    frc = smp_valid && (ce == TO - 1);
    if (smp_valid) begin
      zl = (l == 0) || ((l < 0) != m_nl);
      zr = (r == 0) || ((r < 0) != m_nr);
      if (m_ml != mute_req && (zl || frc)) m_ml = mute_req;
      if (m_mr != mute_req && (zr || frc)) m_mr = mute_req;
      m_ol = m_ml ? 0 : l;
      m_or = m_mr ? 0 : r;
      m_nl = (l < 0);
      m_nr = (r < 0);
      m_cnt = (ce + 1 > TO - 1) ? TO - 1 : ce + 1;
    end else begin
      m_cnt = ce;
    end
    m_reqp = mute_req;
  endtask

  task automatic step();
    @(posedge clk);
    if (live) model_update();
    @(negedge clk);
    if (live) begin
      check_val({cur_tag, " left"},  int'(out_left),  m_ol);
      check_val({cur_tag, " right"}, int'(out_right), m_or);
      check_val({cur_tag, " flag"},  int'(muted),     int'(m_ml && m_mr));
    end
  endtask

  task automatic send(int l, int r);
    in_left   = DW'(l);
    in_right  = DW'(r);
    smp_valid = 1'b1;
    step();
    smp_valid = 1'b0;
    step();
  endtask

  task automatic do_reset(bit req);
    live = 0;
    rst_n = 1'b0; mute_req = req; smp_valid = 1'b0;
    in_left = '0; in_right = '0;
    repeat (3) @(negedge clk);
    check_val("R1 reset left",  int'(out_left),  0);
    check_val("R1 reset right", int'(out_right), 0);
    check_val("R1 reset flag",  int'(muted),     1);
    rst_n = 1'b1;
    repeat (5) step();
    check_val("R1 start state", int'(muted), int'(req));
    m_ml = req; m_mr = req; m_nl = 0; m_nr = 0;
    m_ol = 0; m_or = 0; m_cnt = 0; m_reqp = req;
    live = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0);

    cur_tag = "R2 pass";
    send(100, -50); send(200, -60); send(-300, 70);
    check_val("R2 left value", int'(out_left), -300);

    cur_tag = "R11 hold";
    in_left = 12'sd5; in_right = 12'sd9;
    repeat (3) step();
    check_val("R11 held left", int'(out_left), -300);

    cur_tag = "R5 deferred";
    mute_req = 1'b1;
    send(-10, 20);
    check_val("R5 still passing", int'(out_left), -10);
    send(-20, 30);

    cur_tag = "R6 R10 independent";
    send(15, 40);
    check_val("R6 left switched", int'(out_left), 0);
    check_val("R6 right passing", int'(out_right), 40);
    check_val("R10 one channel", int'(muted), 0);

    cur_tag = "R7 timeout";
    repeat (4) send(16, 41);
    check_val("R7 seventh strobe", int'(out_right), 41);
    send(17, 42);
    check_val("R7 forced right", int'(out_right), 0);
    check_val("R10 both muted", int'(muted), 1);

    cur_tag = "R3 zero output";
    send(500, -500);
    check_val("R3 left zero", int'(out_left), 0);

    cur_tag = "R4 crossing";
    mute_req = 1'b0;
    send(300, -200);
    check_val("R4 no crossing", int'(out_left), 0);
    send(0, -100);
    send(40, -90);
    check_val("R4 zero sample", int'(out_left), 40);
    check_val("R4 right waits", int'(out_right), 0);
    send(41, 90);
    check_val("R4 sign change", int'(out_right), 90);

    cur_tag = "R9 cancel";
    mute_req = 1'b1;
    send(42, 91);
    mute_req = 1'b0;
    send(-5, -6);
    check_val("R9 left kept", int'(out_left), -5);
    check_val("R9 right kept", int'(out_right), -6);

    cur_tag = "R8 restart";
    mute_req = 1'b1;
    repeat (5) send(-1, -2);
    mute_req = 1'b0;
    send(-1, -2);
    mute_req = 1'b1;
    repeat (7) send(-1, -2);
    check_val("R8 not forced early", int'(out_left), -1);
    send(-1, -2);
    check_val("R8 forced after restart", int'(out_left), 0);

    cur_tag = "R1 start muted";
    do_reset(1'b1);
    send(3, 4);
    check_val("R1 muted output", int'(out_left), 0);
    mute_req = 1'b0;
    cur_tag = "R4 R6 after reset";
    send(-3, 4);
    check_val("R4 first crossing", int'(out_left), -3);
    check_val("R6 right stays", int'(out_right), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule